// File: doc/BRIEF.md
# Set-Associative Instruction Address Translator

This block turns instruction-fetch virtual addresses into physical addresses through a set-associative lookaside table. Each table slot is addressed by way and set. A slot holds two words. The match word carries a virtual tag, a valid flag and a small age counter. The translate word carries a physical page number, user and supervisor execute rights and a cache-inhibit flag.

A fetch request is accepted when the block is idle. After a fixed per-outcome latency, a one-cycle response strobe returns the physical address and the cache-inhibit flag, together with exactly one of three outcome pulses: hit, miss or page fault. A miss only reports the event. Refill is left to software, which loads slots through a word-wide register port that can also read any slot back.

A combinational probe port repeats the lookup and the permission check for debug. It never ages entries and never reports an event. When translation is switched off, or the unit is marked absent, addresses pass through unchanged. In that case the top half of the address space is flagged as cache-inhibited.

Top module: `itlb_xlate`

## Requirements
- R1: When `xlate_on` is 0 or `unit_present` is 0, an accepted request responds one cycle after acceptance with `rsp_pa` equal to the request address. `rsp_ci` equals the top address bit, so it is 1 for addresses at 0x80000000 and above. None of hit, miss or fault pulses.
- R2: The set index is VA[PAGE_BITS+SET_BITS-1:PAGE_BITS]. The tag compared is VA[VA_W-1:PAGE_BITS+SET_BITS], matched against the same bit positions of the match word. With the defaults, the tag is VA[31:17] and the set is VA[16:13]. Two addresses that differ only in tag or only in set do not share an entry.
- R3: A way matches only when match-word bit 0 (valid) is 1 and its tag equals the lookup tag. When several ways match, the highest-numbered way supplies the translation.
- R4: On a match, `sup_mode`=1 checks translate-word bit 2 (supervisor execute) and `sup_mode`=0 checks bit 1 (user execute). A clear bit produces a fault pulse, with `rsp_pa`=0 and `rsp_ci`=0.
- R5: On any match, including a faulting one, every way of that set whose age field (match-word bits [LRU_W:1]) is nonzero decrements by one. The matching way's age becomes LRU_STATES-1. Misses, bypassed requests and probes change no age field.
- R6: On a permitted match, `rsp_pa` is the translate word's page number (bits [VA_W-1:PAGE_BITS]) joined with VA[PAGE_BITS-1:0], and `rsp_ci` is translate-word bit 0 with a hit pulse. On a miss, `rsp_pa`=0 and `rsp_ci`=0 with a miss pulse.
- R7: `rsp_hit`, `rsp_miss` and `rsp_fault` are mutually exclusive, occur only with `rsp_valid`, and `rsp_valid` lasts one cycle.
- R8: `prb_pa` returns `prb_va` when translation is inactive. Otherwise it returns the translated address on a permitted match, and 0 on a miss or a permission failure.
- R9: The response appears HIT_LAT+1 cycles after acceptance for a match (hit or fault) and MISS_LAT+1 cycles after for a miss. `req_ready` is 0 from acceptance until the response cycle ends.
- R10: `reg_we` writes `reg_wdata` into the match word (`reg_sel`=0) or the translate word (`reg_sel`=1) of slot (`reg_way`, `reg_set`). `reg_rdata` shows that word combinationally. A lookup accepted in the same cycle as a write uses the old contents. A software write to a match word beats the age update of the same cycle.
- R11: After reset every word is zero, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_on | input | 1 | Translation enable from the status register |
| unit_present | input | 1 | Unit reported as implemented |
| sup_mode | input | 1 | Fetch runs in supervisor mode |
| req_valid | input | 1 | Fetch lookup request |
| req_va | input | VA_W | Fetch virtual address |
| req_ready | output | 1 | Block idle, request accepted |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | VA_W | Physical address |
| rsp_ci | output | 1 | Cache-inhibit |
| rsp_hit | output | 1 | Permitted match |
| rsp_miss | output | 1 | No match |
| rsp_fault | output | 1 | Match without execute permission |
| prb_va | input | VA_W | Probe virtual address |
| prb_pa | output | VA_W | Probe result |
| reg_we | input | 1 | Register write strobe |
| reg_way | input | WAY_W | Slot way |
| reg_set | input | SET_BITS | Slot set |
| reg_sel | input | 1 | 0 match word, 1 translate word |
| reg_wdata | input | VA_W | Write data |
| reg_rdata | output | VA_W | Read data of the addressed word |

## Verification
The assertions assume that a request is only driven while `req_ready` is high. They also assume that `xlate_on` and `unit_present` are steady across the cycle a request is accepted. The stimulus meets both by issuing each request only after the previous response has been collected, and by changing the mode inputs only between transactions. Random tags come from a small pool so that hits, multi-way matches, faults and misses all recur, while the directed cases cover the bypass boundary and same-cycle write collisions.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  typedef enum logic [1:0] {
    RK_PASS  = 2'd0,
    RK_HIT   = 2'd1,
    RK_MISS  = 2'd2,
    RK_FAULT = 2'd3
  } rkind_e;

  // match word: valid bit, age field just above it, tag at the top
  localparam int MR_VALID   = 0;
  localparam int MR_AGE_LSB = 1;
  // translate word: flag positions, page number at the top
  localparam int TR_CI      = 0;
  localparam int TR_UXE     = 1;
  localparam int TR_SXE     = 2;
endpackage

// File: rtl/itlb_store.sv
module itlb_store #(
  parameter int VA_W     = 32,
  parameter int SET_BITS = 4,
  parameter int NWAYS    = 2,
  parameter int WAY_W    = 1,
  parameter int LRU_W    = 2,
  parameter int LRU_MAX  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_we,
  input  logic [WAY_W-1:0]                reg_way,
  input  logic [SET_BITS-1:0]             reg_set,
  input  logic                            reg_sel,
  input  logic [VA_W-1:0]                 reg_wdata,
  output logic [VA_W-1:0]                 reg_rdata,
  input  logic [SET_BITS-1:0]             look_set,
  output logic [NWAYS-1:0][VA_W-1:0]      look_m,
  output logic [NWAYS-1:0][VA_W-1:0]      look_t,
  input  logic [SET_BITS-1:0]             prb_set,
  output logic [NWAYS-1:0][VA_W-1:0]      prb_m,
  output logic [NWAYS-1:0][VA_W-1:0]      prb_t,
  input  logic                            upd_en,
  input  logic [SET_BITS-1:0]             upd_set,
  input  logic [WAY_W-1:0]                upd_way
);
  import itlb_pkg::*;
  localparam int NSETS   = 1 << SET_BITS;
  localparam int AGE_MSB = MR_AGE_LSB + LRU_W - 1;

  logic [VA_W-1:0] mt_q [NWAYS][NSETS];
  logic [VA_W-1:0] tr_q [NWAYS][NSETS];

  function automatic logic [LRU_W-1:0] age_next(input logic [LRU_W-1:0] cur,
                                                input logic is_hit);
    if (is_hit)           return LRU_W'(LRU_MAX);
    else if (cur != '0)   return cur - LRU_W'(1);
    else                  return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWAYS; w++)
        for (int s = 0; s < NSETS; s++) begin
          mt_q[w][s] <= '0;
          tr_q[w][s] <= '0;
        end
    end else begin
      if (upd_en)
        for (int w = 0; w < NWAYS; w++)
          mt_q[w][upd_set][AGE_MSB:MR_AGE_LSB] <=
            age_next(mt_q[w][upd_set][AGE_MSB:MR_AGE_LSB], upd_way == WAY_W'(w));
      // software write is scheduled last so it overrides the age update
      if (reg_we && (int'(reg_way) < NWAYS)) begin
        if (reg_sel) tr_q[reg_way][reg_set] <= reg_wdata;
        else         mt_q[reg_way][reg_set] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_way) < NWAYS)
      reg_rdata = reg_sel ? tr_q[reg_way][reg_set] : mt_q[reg_way][reg_set];
  end

  for (genvar gw = 0; gw < NWAYS; gw++) begin : g_row
    assign look_m[gw] = mt_q[gw][look_set];
    assign look_t[gw] = tr_q[gw][look_set];
    assign prb_m[gw]  = mt_q[gw][prb_set];
    assign prb_t[gw]  = tr_q[gw][prb_set];
  end
endmodule

// File: rtl/itlb_match.sv
module itlb_match #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int SET_BITS  = 4,
  parameter int NWAYS     = 2,
  parameter int WAY_W     = 1
) (
  input  logic [VA_W-1:0]              va,
  input  logic                         sup,
  input  logic [NWAYS-1:0][VA_W-1:0]   m_row,
  input  logic [NWAYS-1:0][VA_W-1:0]   t_row,
  output logic                         tag_hit,
  output logic [WAY_W-1:0]             hit_way,
  output logic                         perm_ok,
  output logic [VA_W-1:0]              hit_pa,
  output logic                         hit_ci
);
  import itlb_pkg::*;
  localparam int TAG_LSB = PAGE_BITS + SET_BITS;

  function automatic logic [VA_W-1:0] join_pa(input logic [VA_W-1:0] tword,
                                              input logic [VA_W-1:0] vaddr);
    return {tword[VA_W-1:PAGE_BITS], vaddr[PAGE_BITS-1:0]};
  endfunction

  function automatic logic tag_eq(input logic [VA_W-1:0] mword,
                                  input logic [VA_W-1:0] vaddr);
    return mword[MR_VALID] && (mword[VA_W-1:TAG_LSB] == vaddr[VA_W-1:TAG_LSB]);
  endfunction

  logic [VA_W-1:0] t_sel;

  // ascending scan: a later match overrides, so the highest way wins
  always_comb begin
    tag_hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < NWAYS; w++)
      if (tag_eq(m_row[w], va)) begin
        tag_hit = 1'b1;
        hit_way = WAY_W'(w);
      end
  end

  assign t_sel   = t_row[hit_way];
  assign perm_ok = sup ? t_sel[TR_SXE] : t_sel[TR_UXE];
  assign hit_pa  = join_pa(t_sel, va);
  assign hit_ci  = t_sel[TR_CI];
endmodule

// File: rtl/itlb_resp.sv
module itlb_resp #(
  parameter int VA_W  = 32,
  parameter int LAT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [LAT_W-1:0]   lat,
  input  itlb_pkg::rkind_e   kind,
  input  logic [VA_W-1:0]    pa,
  input  logic               ci,
  output logic               busy,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic               rsp_fault,
  output logic [VA_W-1:0]    rsp_pa,
  output logic               rsp_ci
);
  import itlb_pkg::*;
  logic             pend_q;
  logic [LAT_W-1:0] cnt_q;
  rkind_e           kind_q;
  logic [VA_W-1:0]  pa_q;
  logic             ci_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= RK_PASS;
      pa_q   <= '0;
      ci_q   <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
      cnt_q  <= lat;
      kind_q <= kind;
      pa_q   <= pa;
      ci_q   <= ci;
    end else if (pend_q) begin
      if (cnt_q == '0) pend_q <= 1'b0;
      else             cnt_q  <= cnt_q - LAT_W'(1);
    end
  end

  assign busy      = pend_q;
  assign rsp_valid = pend_q && (cnt_q == '0);
  assign rsp_hit   = rsp_valid && (kind_q == RK_HIT);
  assign rsp_miss  = rsp_valid && (kind_q == RK_MISS);
  assign rsp_fault = rsp_valid && (kind_q == RK_FAULT);
  assign rsp_pa    = pa_q;
  assign rsp_ci    = ci_q;
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate #(
  parameter int VA_W       = 32,
  parameter int PAGE_BITS  = 13,
  parameter int SET_BITS   = 4,
  parameter int NWAYS      = 2,
  parameter int LRU_STATES = 4,
  parameter int HIT_LAT    = 1,
  parameter int MISS_LAT   = 3,
  localparam int WAY_W     = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xlate_on,
  input  logic                 unit_present,
  input  logic                 sup_mode,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_va,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic [VA_W-1:0]      rsp_pa,
  output logic                 rsp_ci,
  output logic                 rsp_hit,
  output logic                 rsp_miss,
  output logic                 rsp_fault,
  input  logic [VA_W-1:0]      prb_va,
  output logic [VA_W-1:0]      prb_pa,
  input  logic                 reg_we,
  input  logic [WAY_W-1:0]     reg_way,
  input  logic [SET_BITS-1:0]  reg_set,
  input  logic                 reg_sel,
  input  logic [VA_W-1:0]      reg_wdata,
  output logic [VA_W-1:0]      reg_rdata
);
  import itlb_pkg::*;
  localparam int LRU_W   = (LRU_STATES > 2) ? $clog2(LRU_STATES) : 1;
  localparam int LRU_MAX = LRU_STATES - 1;
  localparam int MAX_LAT = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
  localparam int LAT_W   = $clog2(MAX_LAT + 2);

  function automatic logic [SET_BITS-1:0] set_of(input logic [VA_W-1:0] a);
    return a[PAGE_BITS +: SET_BITS];
  endfunction

  // named internal events for the checker
  logic                        xl_act, accept, busy, lru_upd;
  logic [NWAYS-1:0][VA_W-1:0]  f_m, f_t, p_m, p_t;
  logic                        f_tag_hit, f_perm_ok, f_ci;
  logic [WAY_W-1:0]            f_hit_way;
  logic [VA_W-1:0]             f_pa_hit;
  logic                        p_tag_hit, p_perm_ok, p_ci;
  logic [WAY_W-1:0]            p_hit_way;
  logic [VA_W-1:0]             p_pa_hit;
  rkind_e                      f_kind;
  logic [VA_W-1:0]             f_pa;
  logic                        f_ci_out;
  logic [LAT_W-1:0]            f_lat;

  assign xl_act    = xlate_on && unit_present;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign lru_upd   = accept && xl_act && f_tag_hit;

  itlb_store #(
    .VA_W(VA_W), .SET_BITS(SET_BITS), .NWAYS(NWAYS), .WAY_W(WAY_W),
    .LRU_W(LRU_W), .LRU_MAX(LRU_MAX)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_way(reg_way), .reg_set(reg_set), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .look_set(set_of(req_va)), .look_m(f_m), .look_t(f_t),
    .prb_set(set_of(prb_va)), .prb_m(p_m), .prb_t(p_t),
    .upd_en(lru_upd), .upd_set(set_of(req_va)), .upd_way(f_hit_way)
  );

  itlb_match #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS),
    .NWAYS(NWAYS), .WAY_W(WAY_W)
  ) u_fetch_match (
    .va(req_va), .sup(sup_mode), .m_row(f_m), .t_row(f_t),
    .tag_hit(f_tag_hit), .hit_way(f_hit_way), .perm_ok(f_perm_ok),
    .hit_pa(f_pa_hit), .hit_ci(f_ci)
  );

  itlb_match #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS),
    .NWAYS(NWAYS), .WAY_W(WAY_W)
  ) u_probe_match (
    .va(prb_va), .sup(sup_mode), .m_row(p_m), .t_row(p_t),
    .tag_hit(p_tag_hit), .hit_way(p_hit_way), .perm_ok(p_perm_ok),
    .hit_pa(p_pa_hit), .hit_ci(p_ci)
  );

  always_comb begin
    if (!xl_act) begin
      f_kind   = RK_PASS;
      f_pa     = req_va;
      f_ci_out = req_va[VA_W-1];
      f_lat    = '0;
    end else if (!f_tag_hit) begin
      f_kind   = RK_MISS;
      f_pa     = '0;
      f_ci_out = 1'b0;
      f_lat    = LAT_W'(MISS_LAT);
    end else if (!f_perm_ok) begin
      f_kind   = RK_FAULT;
      f_pa     = '0;
      f_ci_out = 1'b0;
      f_lat    = LAT_W'(HIT_LAT);
    end else begin
      f_kind   = RK_HIT;
      f_pa     = f_pa_hit;
      f_ci_out = f_ci;
      f_lat    = LAT_W'(HIT_LAT);
    end
  end

  assign prb_pa = !xl_act ? prb_va :
                  (p_tag_hit && p_perm_ok) ? p_pa_hit : '0;

  itlb_resp #(.VA_W(VA_W), .LAT_W(LAT_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .lat(f_lat),
    .kind(f_kind), .pa(f_pa), .ci(f_ci_out),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .rsp_ci(rsp_ci)
  );
endmodule

// File: rtl/itlb_chk.sv
module itlb_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xl_act,
  input logic            accept,
  input logic [VA_W-1:0] req_va,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_fault,
  input logic [VA_W-1:0] rsp_pa,
  input logic            rsp_ci,
  input logic [VA_W-1:0] prb_va,
  input logic [VA_W-1:0] prb_pa
);
  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !xl_act |=> rsp_valid && (rsp_pa == $past(req_va)) &&
                          (rsp_ci == $past(req_va[VA_W-1])));

  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == '0) && !rsp_ci);

  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_pa == '0) && !rsp_ci);

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_miss, rsp_fault}));

  p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit || rsp_miss || rsp_fault) |-> rsp_valid);

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_probe_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_act |-> (prb_pa == prb_va));
endmodule

bind itlb_xlate itlb_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xl_act(xl_act), .accept(accept),
  .req_va(req_va), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
  .rsp_pa(rsp_pa), .rsp_ci(rsp_ci), .prb_va(prb_va), .prb_pa(prb_pa)
);

// File: tb/sim_itlb_xlate.sv
`timescale 1ns/1ps
module sim_itlb_xlate;
  localparam int PG   = 8192;
  localparam int NS   = 16;
  localparam int NW   = 2;
  localparam int HLAT = 1;
  localparam int MLAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xlate_on = 1'b0, unit_present = 1'b1, sup_mode = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic req_ready, rsp_valid, rsp_ci, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_pa;
  logic [31:0] prb_va = '0;
  logic [31:0] prb_pa;
  logic reg_we = 1'b0;
  logic [0:0] reg_way = '0;
  logic [3:0] reg_set = '0;
  logic reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  logic [31:0] bm [NW][NS];
  logic [31:0] bt [NW][NS];

  always #5 clk = ~clk;

  itlb_xlate u0 (
    .clk(clk), .rst_n(rst_n), .xlate_on(xlate_on), .unit_present(unit_present),
    .sup_mode(sup_mode), .req_valid(req_valid), .req_va(req_va),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_ci(rsp_ci), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .prb_va(prb_va), .prb_pa(prb_pa),
    .reg_we(reg_we), .reg_way(reg_way), .reg_set(reg_set), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench model: kind 0 pass, 1 hit, 2 miss, 3 fault; way -1 when no match
  task automatic model(input logic [31:0] va, input bit sup, output int kind,
                       output logic [31:0] pa, output bit ci, output int way);
    int s;
    logic [31:0] vpn, t;
    way = -1;
    if (!(xlate_on && unit_present)) begin
      kind = 0; pa = va; ci = (va >= 32'h8000_0000); return;
    end
    s   = int'((va / PG) % NS);
    vpn = va / (PG * NS);
    for (int w = NW - 1; w >= 0; w--)
      if (way < 0 && bm[w][s][0] && (bm[w][s] / (PG * NS)) == vpn) way = w;
    if (way < 0) begin kind = 2; pa = 0; ci = 0; return; end
    t = bt[way][s];
    if (!(sup ? t[2] : t[1])) begin kind = 3; pa = 0; ci = 0; return; end
    kind = 1; pa = (t / PG) * PG + (va % PG); ci = t[0];
  endtask

  task automatic model_age(input int s, input int way);
    for (int w = 0; w < NW; w++) begin
      int a;
      a = int'((bm[w][s] >> 1) & 32'h3);
      if (w == way) a = 3;
      else if (a > 0) a = a - 1;
      bm[w][s] = (bm[w][s] & ~32'h6) | (32'(a) << 1);
    end
  endtask

  task automatic model_write(input int w, input int s, input bit sel, input logic [31:0] d);
    if (sel) bt[w][s] = d; else bm[w][s] = d;
  endtask

  task automatic wr(input int w, input int s, input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_way = 1'(w); reg_set = 4'(s); reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    model_write(w, s, sel, d);
  endtask

  task automatic readback(input int w, input int s, input bit sel, input string req);
    @(negedge clk);
    reg_way = 1'(w); reg_set = 4'(s); reg_sel = sel;
    #1;
    chk(reg_rdata == (sel ? bt[w][s] : bm[w][s]), req, "readback",
        reg_rdata, sel ? bt[w][s] : bm[w][s]);
  endtask

  task automatic lookup(input logic [31:0] va, input bit sup, input string req,
                        input bit dw, input int ww, input int ws, input bit wsel,
                        input logic [31:0] wd);
    int kind, way, n, elat;
    logic [31:0] epa;
    bit eci;
    logic [2:0] eflags;
    model(va, sup, kind, epa, eci, way);
    @(negedge clk);
    req_valid = 1; req_va = va; sup_mode = sup;
    if (dw) begin
      reg_we = 1; reg_way = 1'(ww); reg_set = 4'(ws); reg_sel = wsel; reg_wdata = wd;
    end
    @(negedge clk);
    req_valid = 0; reg_we = 0;
    if (way >= 0) model_age(int'((va / PG) % NS), way);
    if (dw) model_write(ww, ws, wsel, wd);
    n = 1;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    elat = (kind == 0) ? 1 : (kind == 2) ? MLAT + 1 : HLAT + 1;
    chk(n == elat, "R9", "latency", 32'(n), 32'(elat));
    eflags = (kind == 1) ? 3'b100 : (kind == 2) ? 3'b010 : (kind == 3) ? 3'b001 : 3'b000;
    chk({rsp_hit, rsp_miss, rsp_fault} == eflags, req, "outcome",
        32'({rsp_hit, rsp_miss, rsp_fault}), 32'(eflags));
    chk(rsp_pa == epa, req, "pa", rsp_pa, epa);
    chk(rsp_ci == eci, req, "ci", 32'(rsp_ci), 32'(eci));
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R7", "strobe one cycle", 32'(rsp_valid), 0);
  endtask

  task automatic probe(input logic [31:0] va, input bit sup, input string req);
    int kind, way;
    logic [31:0] epa;
    bit eci;
    model(va, sup, kind, epa, eci, way);
    if (kind == 2 || kind == 3) epa = 0;
    @(negedge clk);
    prb_va = va; sup_mode = sup;
    #1;
    chk(prb_pa == epa, req, "probe", prb_pa, epa);
  endtask

  function automatic logic [31:0] mva(input int tag, input int s, input int off);
    return (32'(tag) * PG * NS) + (32'(s) * PG) + 32'(off);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] A;
    int seed;
    seed = $urandom(32'd1234);
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) begin bm[w][s] = 0; bt[w][s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R11", "idle after reset", 32'({req_ready, rsp_valid}), 32'b10);
    readback(1, 7, 0, "R11");
    readback(0, 15, 1, "R11");

    // bypass boundary
    xlate_on = 0;
    lookup(32'h7FFF_FFFC, 0, "R1", 0, 0, 0, 0, 0);
    lookup(32'h8000_0000, 1, "R1", 0, 0, 0, 0, 0);
    xlate_on = 1; unit_present = 0;
    lookup(32'h9000_1234, 0, "R1", 0, 0, 0, 0, 0);
    probe(32'hDEAD_BEEF, 0, "R8");
    unit_present = 1;

    lookup(32'h0000_6000, 0, "R6", 0, 0, 0, 0, 0);

    A = mva(5, 3, 'h123);
    wr(0, 3, 0, mva(5, 0, 0) | 32'h1);
    wr(0, 3, 1, (32'h2AA * PG) | 32'h6);
    lookup(A, 0, "R6", 0, 0, 0, 0, 0);
    readback(0, 3, 0, "R5");
    wr(1, 3, 0, mva(5, 0, 0) | 32'h5);
    wr(1, 3, 1, (32'h155 * PG) | 32'h3);
    lookup(A, 0, "R3", 0, 0, 0, 0, 0);
    readback(0, 3, 0, "R5");
    readback(1, 3, 0, "R5");
    lookup(A, 1, "R4", 0, 0, 0, 0, 0);
    readback(0, 3, 0, "R5");
    lookup(mva(6, 3, 'h123), 0, "R2", 0, 0, 0, 0, 0);
    lookup(mva(5, 4, 'h123), 0, "R2", 0, 0, 0, 0, 0);
    readback(0, 3, 0, "R5");

    probe(A, 0, "R8");
    probe(A, 1, "R8");
    probe(mva(9, 3, 0), 0, "R8");
    readback(0, 3, 0, "R8");
    readback(1, 3, 0, "R8");

    lookup(A, 0, "R10", 1, 1, 3, 1, (32'h0F0 * PG) | 32'h2);
    lookup(A, 0, "R10", 0, 0, 0, 0, 0);
    lookup(A, 0, "R10", 1, 0, 3, 0, mva(5, 0, 0) | 32'h1);
    readback(0, 3, 0, "R10");
    readback(1, 3, 0, "R5");
    wr(1, 3, 0, mva(5, 0, 0));
    lookup(A, 1, "R3", 0, 0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 8);
      xlate_on = (r != 0);
      if ($urandom % 4 == 0) begin
        int w, s;
        bit sel;
        logic [31:0] d;
        w = int'($urandom % NW); s = int'($urandom % NS); sel = 1'($urandom % 2);
        d = $urandom;
        if (!sel) d = mva(int'($urandom % 3) + 1, 0, 0) | (d & 32'h0000_1FFF);
        wr(w, s, sel, d);
      end
      lookup(mva(int'($urandom % 4) + 1, int'($urandom % NS), int'($urandom % PG)) |
             ((($urandom % 8) == 0) ? 32'h8000_0000 : 32'h0),
             1'($urandom % 2), "R6", 0, 0, 0, 0, 0);
      if (i % 16 == 0) begin
        probe(mva(int'($urandom % 4) + 1, int'($urandom % NS), 'h40), 1'($urandom % 2), "R8");
        readback(int'($urandom % NW), int'($urandom % NS), 1'($urandom % 2), "R5");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule